// File: doc/BRIEF.md
# Flagged Integer ALU

A combinational integer arithmetic unit paired with a small registered flag store holding a carry flag (CA), an overflow flag (OV) and a sticky summary overflow flag (SO). Each operation produces its result and a 4-bit condition nibble in the same cycle. The flags are written at the next clock edge when the operation is strobed valid.

Arithmetic covers plain, carrying and extended additions. Extended forms take the stored CA as carry-in and also include add-to-minus-one and add-to-zero. A matching set of reversed subtractions computes the second operand minus the first. Negation, logical shifts by a register amount, and algebraic right shifts by a register or an immediate amount complete the set. The opcode fixes whether CA is written. An overflow-check input decides whether an arithmetic operation writes OV and SO.

A pipeline feeds one operation per cycle. It reads the result and the condition nibble combinationally. It uses the flag outputs as the carry and overflow state that later operations see.

Top module: `ialu_flagged`

## Requirements
- R1: Add opcodes: ADD=0 (a+b), ADDC=1 (a+b), ADDX=2 (a+b+CA), ADDM1X=3 (a+0xFFFFFFFF+CA) and ADDZX=4 (a+CA). Codes 1 to 4 write CA with the unsigned carry out of the sum. ADD leaves CA unchanged.
- R2: Reversed subtract opcodes: RSUB=5 (b-a), RSUBC=6 (b-a), RSUBX=7 (b+~a+CA), RSUBM1X=8 (~a+0xFFFFFFFF+CA) and RSUBZX=9 (~a+CA). Codes 6 to 9 write CA with the carry out. For RSUBC this means CA=1 exactly when the result is at most b (unsigned). RSUB leaves CA unchanged.
- R3: When ovf_chk_i=1, opcodes 0 to 10 write OV. OV is 1 on signed overflow, and signed overflow also sets SO. A result with no overflow clears OV and leaves SO unchanged. With ovf_chk_i=0, or for opcodes 11 to 15, OV and SO are unchanged.
- R4: NEG=10 gives the two's complement of a. For a=0x80000000 the result equals a and counts as an overflow. NEG never writes CA.
- R5: SHL=11 and SHR=12 shift a logically by b[4:0]. The result is zero when b[5]=1. Neither writes CA.
- R6: SAR=13 shifts a arithmetically by b[5:0]. For amounts of 32 or more, every result bit equals a[31] and CA equals a[31]. Otherwise CA is 1 only when a is negative and a one bit was shifted out.
- R7: SARI=14 shifts a arithmetically by shamt_i and ignores b. CA follows the same rule as SAR.
- R8: cond_o bit 3 is 1 for a negative result, bit 2 for a positive result and bit 1 for a zero result. Bit 0 is the SO value that the current operation would leave.
- R9: Flags change only at a clock edge with valid_i=1. clr_i=1 zeroes CA, OV and SO at the edge and takes priority over valid_i.
- R10: While rst_n is low, and for two clock edges after it rises, CA, OV and SO read zero.
- R11: Opcode 15 gives a zero result and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Operation strobe; allows the flag write |
| clr_i | input | 1 | Zeroes all three flags at the edge |
| op_i | input | 4 | Opcode (see R1 to R11) |
| ovf_chk_i | input | 1 | Enables the OV/SO write for arithmetic opcodes |
| a_i | input | W | First operand |
| b_i | input | W | Second operand or register shift amount |
| shamt_i | input | log2(W) | Immediate shift amount for SARI |
| result_o | output | W | Combinational result |
| cond_o | output | 4 | Condition nibble {neg, pos, zero, so} |
| ca_o | output | 1 | Carry flag |
| ov_o | output | 1 | Overflow flag |
| so_o | output | 1 | Sticky summary overflow flag |

## Verification
The bench builds the block at the default width of 32. At this width the shift-amount boundary sits at bit 5, so amounts 31, 32 and 63 can be hit directly. The most negative operand 0x80000000 and the all-ones operand are also directly reachable. These values drive the negation overflow case, the carry edges of the extended forms (0xFFFFFFFF plus carry-in) and the sign-filling shift to 32 and beyond. Random operands are drawn with a bias toward these values, so the carry and overflow edges recur under many flag histories.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  typedef enum logic [3:0] {
    OP_ADD     = 4'd0,
    OP_ADDC    = 4'd1,
    OP_ADDX    = 4'd2,
    OP_ADDM1X  = 4'd3,
    OP_ADDZX   = 4'd4,
    OP_RSUB    = 4'd5,
    OP_RSUBC   = 4'd6,
    OP_RSUBX   = 4'd7,
    OP_RSUBM1X = 4'd8,
    OP_RSUBZX  = 4'd9,
    OP_NEG     = 4'd10,
    OP_SHL     = 4'd11,
    OP_SHR     = 4'd12,
    OP_SAR     = 4'd13,
    OP_SARI    = 4'd14,
    OP_NONE    = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2
  } sh_kind_e;

  function automatic logic op_writes_ca(alu_op_e op);
    case (op)
      OP_ADDC, OP_ADDX, OP_ADDM1X, OP_ADDZX,
      OP_RSUBC, OP_RSUBX, OP_RSUBM1X, OP_RSUBZX,
      OP_SAR, OP_SARI: return 1'b1;
      default:         return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    return (op <= OP_NEG);
  endfunction

  function automatic logic op_is_shift(alu_op_e op);
    return (op >= OP_SHL) && (op <= OP_SARI);
  endfunction

endpackage

// File: rtl/ialu_addsub.sv
module ialu_addsub
  import ialu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           ca_i,
  output logic [W-1:0]   sum_o,
  output logic           co_o,
  output logic           ovf_o
);

  logic [W-1:0] x_op;
  logic [W-1:0] y_op;
  logic         cin;
  logic [W:0]   wide;

  // Operand steering: every form reduces to x + y + cin
  always_comb begin
    x_op = a_i;
    y_op = '0;
    cin  = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDC: y_op = b_i;
      OP_ADDX:         begin y_op = b_i; cin = ca_i; end
      OP_ADDM1X:       begin y_op = '1;  cin = ca_i; end
      OP_ADDZX:        cin = ca_i;
      OP_RSUB, OP_RSUBC: begin x_op = ~a_i; y_op = b_i; cin = 1'b1; end
      OP_RSUBX:        begin x_op = ~a_i; y_op = b_i; cin = ca_i; end
      OP_RSUBM1X:      begin x_op = ~a_i; y_op = '1;  cin = ca_i; end
      OP_RSUBZX:       begin x_op = ~a_i; cin = ca_i; end
      OP_NEG:          begin x_op = ~a_i; cin = 1'b1; end
      default: ;
    endcase
  end

  assign wide  = {1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, cin};
  assign sum_o = wide[W-1:0];
  assign co_o  = wide[W];
  // Same-signed addends with a differently signed sum
  assign ovf_o = (x_op[W-1] == y_op[W-1]) && (sum_o[W-1] != x_op[W-1]);

endmodule

// File: rtl/ialu_shifter.sv
module ialu_shifter
  import ialu_pkg::*;
#(
  parameter int W  = 32,
  parameter int NB = $clog2(W)
) (
  input  sh_kind_e       kind_i,
  input  logic [W-1:0]   a_i,
  input  logic [NB:0]    amt_i,
  output logic [W-1:0]   res_o,
  output logic           ca_o
);

  logic [NB-1:0] n;
  logic          big;
  logic          sign;
  logic [W-1:0]  lost_mask;

  assign n         = amt_i[NB-1:0];
  assign big       = amt_i[NB];
  assign sign      = a_i[W-1];
  assign lost_mask = ~({W{1'b1}} << n);

  always_comb begin
    res_o = '0;
    ca_o  = 1'b0;
    case (kind_i)
      SH_LEFT:  res_o = big ? '0 : (a_i << n);
      SH_RIGHT: res_o = big ? '0 : (a_i >> n);
      SH_ARITH: begin
        if (big) begin
          res_o = {W{sign}};
          ca_o  = sign;
        end else begin
          res_o = $signed(a_i) >>> n;
          ca_o  = sign & (|(a_i & lost_mask));
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ialu_flagreg.sv
module ialu_flagreg (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic clr_i,
  input  logic ca_we_i,
  input  logic ca_i,
  input  logic ov_we_i,
  input  logic ov_i,
  output logic ca_o,
  output logic ov_o,
  output logic so_o,
  output logic so_next_o
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       ca_q, ov_q, so_q;
  logic       ca_d, ov_d, so_d;
  logic       flag_en;

  // Assert asynchronously, release after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign so_next_o = so_q | (ov_we_i & ov_i);
  assign flag_en   = clr_i | valid_i;

  always_comb begin
    ca_d = ca_q;
    ov_d = ov_q;
    so_d = so_q;
    if (clr_i) begin
      ca_d = 1'b0;
      ov_d = 1'b0;
      so_d = 1'b0;
    end else begin
      if (ca_we_i) ca_d = ca_i;
      if (ov_we_i) begin
        ov_d = ov_i;
        so_d = so_next_o;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ca_q <= 1'b0;
      ov_q <= 1'b0;
      so_q <= 1'b0;
    end else if (flag_en) begin
      ca_q <= ca_d;
      ov_q <= ov_d;
      so_q <= so_d;
    end
  end

  assign ca_o = ca_q;
  assign ov_o = ov_q;
  assign so_o = so_q;

endmodule

// File: rtl/ialu_flagged.sv
module ialu_flagged
  import ialu_pkg::*;
#(
  parameter  int W  = 32,
  localparam int NB = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          clr_i,
  input  logic [3:0]    op_i,
  input  logic          ovf_chk_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [NB-1:0] shamt_i,
  output logic [W-1:0]  result_o,
  output logic [3:0]    cond_o,
  output logic          ca_o,
  output logic          ov_o,
  output logic          so_o
);

  alu_op_e      op;
  sh_kind_e     kind;
  logic [NB:0]  amt;
  logic [W-1:0] sum, sh_res;
  logic         co, ovf, sh_ca;
  logic         ca_we, ov_we, ca_new, so_next;

  assign op = alu_op_e'(op_i);

  ialu_addsub #(.W(W)) u_addsub (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .ca_i  (ca_o),
    .sum_o (sum),
    .co_o  (co),
    .ovf_o (ovf)
  );

  always_comb begin
    case (op)
      OP_SHL:  kind = SH_LEFT;
      OP_SHR:  kind = SH_RIGHT;
      default: kind = SH_ARITH;
    endcase
  end

  assign amt = (op == OP_SARI) ? {1'b0, shamt_i} : b_i[NB:0];

  ialu_shifter #(.W(W), .NB(NB)) u_shift (
    .kind_i (kind),
    .a_i    (a_i),
    .amt_i  (amt),
    .res_o  (sh_res),
    .ca_o   (sh_ca)
  );

  always_comb begin
    if (op_is_arith(op))      result_o = sum;
    else if (op_is_shift(op)) result_o = sh_res;
    else                      result_o = '0;
  end

  assign ca_we  = op_writes_ca(op);
  assign ca_new = op_is_shift(op) ? sh_ca : co;
  assign ov_we  = op_is_arith(op) & ovf_chk_i;

  ialu_flagreg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .clr_i     (clr_i),
    .ca_we_i   (ca_we),
    .ca_i      (ca_new),
    .ov_we_i   (ov_we),
    .ov_i      (ovf),
    .ca_o      (ca_o),
    .ov_o      (ov_o),
    .so_o      (so_o),
    .so_next_o (so_next)
  );

  assign cond_o = {result_o[W-1],
                   ~result_o[W-1] & (|result_o),
                   ~(|result_o),
                   so_next};

endmodule

// File: rtl/ialu_flagged_chk.sv
module ialu_flagged_chk
  import ialu_pkg::*;
#(
  parameter  int W  = 32,
  localparam int NB = $clog2(W)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_i,
  input logic         clr_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic [3:0]   cond_o,
  input logic         ca_o,
  input logic         ov_o,
  input logic         so_o
);

  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!ca_o && !ov_o && !so_o)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !clr_i) |=> $stable({ca_o, ov_o, so_o})); // R9
  AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (so_o && !clr_i) |=> so_o); // R3
  AST_OV_NEEDS_SO: assert property (@(posedge clk) disable iff (!rst_n)
    ov_o |-> so_o); // R3
  AST_COND_ONE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cond_o[3:1]) == 1); // R8
  AST_RSUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RSUB) |-> (result_o == b_i - a_i)); // R2
  AST_NEG_MIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NEG && a_i == MIN_NEG) |-> (result_o == MIN_NEG)); // R4
  AST_SHIFT_WIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_SHL || op_i == OP_SHR) && b_i[NB]) |-> (result_o == '0)); // R5
  AST_SAR_WIDE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SAR && b_i[NB]) |-> (result_o == {W{a_i[W-1]}})); // R6
  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NONE && !clr_i) |=> $stable({ca_o, ov_o, so_o})); // R11

endmodule

bind ialu_flagged ialu_flagged_chk #(.W(W)) u_chk (.*);

// File: tb/ialu_flagged_tb.sv
`timescale 1ns/1ps
module ialu_flagged_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, clr_i, ovf_chk_i;
  logic [3:0]  op_i;
  logic [31:0] a_i, b_i;
  logic [4:0]  shamt_i;
  logic [31:0] result_o;
  logic [3:0]  cond_o;
  logic        ca_o, ov_o, so_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic m_ca, m_ov, m_so;

  always #10 clk = ~clk;

  ialu_flagged #(.W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .clr_i(clr_i),
    .op_i(op_i), .ovf_chk_i(ovf_chk_i), .a_i(a_i), .b_i(b_i),
    .shamt_i(shamt_i), .result_o(result_o), .cond_o(cond_o),
    .ca_o(ca_o), .ov_o(ov_o), .so_o(so_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    if (op <= 4)  return "R1";
    if (op <= 9)  return "R2";
    if (op == 10) return "R4";
    if (op <= 12) return "R5";
    if (op == 13) return "R6";
    if (op == 14) return "R7";
    return "R11";
  endfunction

  // Reference model written from the requirement text
  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input logic cin,
                       output logic [31:0] r, output logic ca_new, output logic ca_we,
                       output logic ovf, output logic ov_cap);
    longint sa, sb, sv;
    logic [31:0] na;
    int n;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    na = ~a;
    sv = 0; r = '0; ca_new = 1'b0; ca_we = 1'b0;
    ov_cap = (op <= 10);
    case (op)
      0: begin r = a + b; sv = sa + sb; end
      1: begin r = a + b; sv = sa + sb; ca_we = 1; ca_new = (r < a); end
      2: begin r = a + b + {31'd0, cin}; sv = sa + sb + longint'(cin);
               ca_we = 1; ca_new = (r < a) || (cin && r == a); end
      3: begin r = a + {31'd0, cin} - 32'd1; sv = sa - 1 + longint'(cin);
               ca_we = 1; ca_new = (a != 0) ? 1'b1 : cin; end
      4: begin r = a + {31'd0, cin}; sv = sa + longint'(cin); ca_we = 1; ca_new = (r < a); end
      5: begin r = b - a; sv = sb - sa; end
      6: begin r = b - a; sv = sb - sa; ca_we = 1; ca_new = (r <= b); end
      7: begin r = b + na + {31'd0, cin}; sv = sb - sa - 1 + longint'(cin);
               ca_we = 1; ca_new = (r < b) || (cin && r == b); end
      8: begin r = na + {31'd0, cin} - 32'd1; sv = -sa - 2 + longint'(cin);
               ca_we = 1; ca_new = (a != 32'hFFFF_FFFF) ? 1'b1 : cin; end
      9: begin r = na + {31'd0, cin}; sv = -sa - 1 + longint'(cin); ca_we = 1; ca_new = (r < na); end
      10: begin r = (a == 32'h8000_0000) ? a : (32'd0 - a); sv = -sa; end
      11: r = b[5] ? 32'd0 : (a << b[4:0]);
      12: r = b[5] ? 32'd0 : (a >> b[4:0]);
      13, 14: begin
        ca_we = 1;
        if (op == 13 && b[5]) begin
          r = {32{a[31]}}; ca_new = a[31];
        end else begin
          n = (op == 13) ? int'(b[4:0]) : int'(sh);
          r = 32'($signed(a) >>> n);
          ca_new = a[31] && ((a & 32'((64'd1 << n) - 1)) != 0);
        end
      end
      default: r = '0;
    endcase
    ovf = ov_cap && (sv > 64'sd2147483647 || sv < -64'sd2147483648);
  endtask

  task automatic do_op(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input logic ovf_en, input logic vld, input logic clr);
    logic [31:0] r;
    logic ca_new, ca_we, ovf, ov_cap, ov_we, so_after;
    logic [3:0] exp_cond;
    string ftag;
    @(negedge clk);
    op_i = op[3:0]; a_i = a; b_i = b; shamt_i = sh;
    ovf_chk_i = ovf_en; valid_i = vld; clr_i = clr;
    model(op, a, b, sh, m_ca, r, ca_new, ca_we, ovf, ov_cap);
    ov_we    = ov_cap && ovf_en;
    so_after = m_so | (ov_we & ovf);
    exp_cond = {r[31], !r[31] && r != 0, r == 0, so_after};
    #2;
    check(result_o == r, req_of(op), result_o, r);
    check(cond_o == exp_cond, "R8", {28'd0, cond_o}, {28'd0, exp_cond});
    if (clr) begin
      m_ca = 0; m_ov = 0; m_so = 0; ftag = "R9";
    end else if (vld) begin
      if (ca_we) m_ca = ca_new;
      if (ov_we) begin m_ov = ovf; m_so = so_after; end
      ftag = ov_we ? "R3" : req_of(op);
    end else begin
      ftag = "R9";
    end
    @(posedge clk);
    #2;
    check({ca_o, ov_o, so_o} == {m_ca, m_ov, m_so}, ftag,
          {29'd0, ca_o, ov_o, so_o}, {29'd0, m_ca, m_ov, m_so});
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h8000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return 32'd0;
      4: return {26'd0, 6'($urandom_range(0, 63))};
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=0x%08h expected=0x%08h", checks, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; valid_i = 0; clr_i = 0; ovf_chk_i = 0;
    op_i = 0; a_i = 0; b_i = 0; shamt_i = 0;
    m_ca = 0; m_ov = 0; m_so = 0;
    repeat (3) @(posedge clk);
    #2;
    check({ca_o, ov_o, so_o} == 3'b000, "R10", {29'd0, ca_o, ov_o, so_o}, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    check({ca_o, ov_o, so_o} == 3'b000, "R10", {29'd0, ca_o, ov_o, so_o}, 0);

    // R1 carry edges
    do_op(1, 32'hFFFF_FFFF, 32'd1, 0, 0, 1, 0);
    do_op(2, 32'hFFFF_FFFF, 32'd0, 0, 0, 1, 0);
    do_op(3, 32'd0, 32'd0, 0, 0, 1, 0);
    do_op(4, 32'hFFFF_FFFF, 32'd0, 0, 0, 1, 0);
    // R3 overflow set, then clear with SO kept, then check disabled
    do_op(0, 32'h7FFF_FFFF, 32'd1, 0, 1, 1, 0);
    do_op(0, 32'd1, 32'd1, 0, 1, 1, 0);
    do_op(0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 1, 0);
    do_op(11, 32'h8000_0000, 32'd1, 0, 1, 1, 0);
    // R9 clear, then strobe low
    do_op(1, 32'hFFFF_FFFF, 32'd1, 0, 1, 1, 1);
    do_op(1, 32'hFFFF_FFFF, 32'd1, 0, 1, 0, 0);
    // R2 reversed subtract edges
    do_op(6, 32'd5, 32'd5, 0, 0, 1, 0);
    do_op(6, 32'd6, 32'd5, 0, 0, 1, 0);
    do_op(7, 32'd0, 32'hFFFF_FFFF, 0, 1, 1, 0);
    do_op(8, 32'hFFFF_FFFF, 32'd0, 0, 1, 1, 0);
    do_op(9, 32'd0, 32'd0, 0, 1, 1, 0);
    // R4 negate the most negative value
    do_op(10, 32'h8000_0000, 32'd0, 0, 1, 1, 0);
    do_op(10, 32'd7, 32'd0, 0, 1, 1, 0);
    // R5 shift amounts around 32
    do_op(11, 32'hA5A5_A5A5, 32'd31, 0, 0, 1, 0);
    do_op(11, 32'hA5A5_A5A5, 32'd32, 0, 0, 1, 0);
    do_op(12, 32'hA5A5_A5A5, 32'd63, 0, 0, 1, 0);
    // R6 algebraic shift by register
    do_op(13, 32'hF000_0000, 32'd40, 0, 0, 1, 0);
    do_op(13, 32'h8000_0000, 32'd4, 0, 0, 1, 0);
    do_op(13, 32'h8000_0001, 32'd1, 0, 0, 1, 0);
    do_op(13, 32'h0000_0001, 32'd1, 0, 0, 1, 0);
    // R7 algebraic shift by immediate
    do_op(14, 32'hFFFF_FFF9, 32'd0, 5'd3, 0, 1, 0);
    do_op(14, 32'hFFFF_FFF9, 32'd0, 5'd0, 0, 1, 0);
    // R11 reserved opcode
    do_op(1, 32'hFFFF_FFFF, 32'd1, 0, 0, 1, 0);
    do_op(15, 32'h1234_5678, 32'h1, 0, 1, 1, 0);

    for (int i = 0; i < 1500; i++) begin
      do_op(int'($urandom_range(0, 15)), pick_val(), pick_val(),
            5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 9) != 0), ($urandom_range(0, 39) == 0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule